// File: doc/BRIEF.md
# Reset Strap Capture and Pin-Mode Controller

This block reads board straps on pins that are shared with control outputs. While reset is held, and for a fixed window of clocks after it is released, every shared pin is left undriven and its level is sampled. The straps give the operating role (host side or dock side), the dock sub-role (hub or dongle), a firmware-update request, and a two-bit supply-voltage code read from the pair of mux-select pins.

When the window closes the captured values are frozen until the next reset, and one clock later a configuration-valid flag rises. From then on the pins become outputs. On the host side the two mux-select pins repeat the host's select inputs. On the dock side the three voltage-control pins carry one-hot supply-rail enables decoded from the voltage code, and a lane-mode input is reported as a 2/4-lane flag. Each shared pin is modelled as an input, an output value and an output enable, and board-level resolution happens outside the block.

Top module: `strap_cfg_top`

## Requirements
- R1: `isHost` equals the level of `modePinIn` (1 = host side, 0 = dock side) in the last clock of the capture window.
- R2: `voltCode` equals {`hsSelPinIn`, `ssSelPinIn`} as captured, the high-speed select pin giving bit 1. The codes are 00 = off, 01 = 12 V, 10 = 19 V and 11 = 5 V.
- R3: `fwUpdate` equals the captured `commReqPinIn`. After `cfgValid` rises, `commReq` follows `commReqPinIn`. Before that it is 0.
- R4: `isDongle` equals the captured `vctl1PinIn` (0 = hub, 1 = dongle) on the dock side, and is 0 on the host side.
- R5: In reset, and for the CAPTURE_CYCLES (default 8) clocks after reset is released, every output enable and `cfgValid` is 0. `cfgValid` rises at clock edge CAPTURE_CYCLES+1 after release and then stays high until reset.
- R6: After the window, a change on any strap pin leaves `isHost`, `voltCode`, `fwUpdate` and `isDongle` unchanged until the next reset.
- R7: On the host side with `cfgValid` high, `hsSelPinOe` and `ssSelPinOe` are 1, and `hsSelPinOut` and `ssSelPinOut` follow `hostHsSel` and `hostSsSel` (0 = DisplayPort, 1 = USB). On the dock side both select enables stay 0.
- R8: `railEn` is {19 V, 12 V, 5 V} and is one-hot for codes 01, 10 and 11 on the dock side with `cfgValid` high. It is all zero for code 00, when `fwUpdate` is set, on the host side, and before `cfgValid`.
- R9: On the dock side with `cfgValid` high, `vctlPinOe` is 111 and `vctlPinOut` equals `railEn`. On the host side `vctlPinOe` is 000.
- R10: `fourLane` follows `laneModeIn` (0 = 2-lane, 1 = 4-lane) on the dock side with `cfgValid` high, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modePinIn | input | 1 | Role strap pin level |
| hsSelPinIn | input | 1 | High-speed select pin level (voltage code bit 1) |
| hsSelPinOut | output | 1 | High-speed select drive value |
| hsSelPinOe | output | 1 | High-speed select drive enable |
| ssSelPinIn | input | 1 | SuperSpeed select pin level (voltage code bit 0) |
| ssSelPinOut | output | 1 | SuperSpeed select drive value |
| ssSelPinOe | output | 1 | SuperSpeed select drive enable |
| vctl1PinIn | input | 1 | First voltage-control pin level (sub-role strap) |
| vctlPinOut | output | 3 | Voltage-control drive values {19 V, 12 V, 5 V} |
| vctlPinOe | output | 3 | Voltage-control drive enables |
| commReqPinIn | input | 1 | Communication-request pin level |
| hostHsSel | input | 1 | Host high-speed select request |
| hostSsSel | input | 1 | Host SuperSpeed select request |
| laneModeIn | input | 1 | Dock lane-mode input |
| cfgValid | output | 1 | Capture complete, pins driven |
| isHost | output | 1 | Captured role |
| isDongle | output | 1 | Captured dock sub-role |
| fwUpdate | output | 1 | Captured firmware-update request |
| voltCode | output | 2 | Captured voltage code |
| railEn | output | 3 | One-hot rail enables {19 V, 12 V, 5 V} |
| fourLane | output | 1 | 4-lane mode flag |
| commReq | output | 1 | Communication request after capture |

## Verification
The bench runs every combination of the five strap levels through a reset and capture cycle. For each one it watches each clock of the window, so a design that drove a pin early would contend with the strap and could read back its own output instead of the board level. It checks the exact edge at which `cfgValid` rises; an off-by-one counter would show up as the flag arriving a clock early or late. After capture it flips all straps and confirms that the captured values hold, which catches a design that keeps sampling. It also checks that code 00 and a firmware-update strap both leave every rail off, so a decoder that let either case through would be reported.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int NUM_RAILS = 3;
  localparam int RAIL_5  = 0;
  localparam int RAIL_12 = 1;
  localparam int RAIL_19 = 2;

  typedef enum logic [1:0] {
    VOLT_OFF = 2'b00,
    VOLT_12  = 2'b01,
    VOLT_19  = 2'b10,
    VOLT_5   = 2'b11
  } voltCode_e;

  typedef struct packed {
    logic captureEn;
    logic cfgValid;
  } strapStrobe_t;

  function automatic logic [NUM_RAILS-1:0] decodeRail(input logic [1:0] code);
    logic [NUM_RAILS-1:0] r;
    r = '0;
    case (voltCode_e'(code))
      VOLT_12: r[RAIL_12] = 1'b1;
      VOLT_19: r[RAIL_19] = 1'b1;
      VOLT_5:  r[RAIL_5]  = 1'b1;
      default: r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/strap_ctrl.sv
module strap_ctrl
  import strap_pkg::*;
#(
  parameter int CAPTURE_CYCLES = 8
) (
  input  logic         clk,
  input  logic         rstN,
  output strapStrobe_t strobe
);
  localparam int CW = $clog2(CAPTURE_CYCLES + 1);
  localparam logic [CW-1:0] WIN_END = CW'(CAPTURE_CYCLES);

  logic [CW-1:0] winCnt;
  logic          validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      validQ <= 1'b0;
    end else if (winCnt < WIN_END) begin
      winCnt <= winCnt + 1'b1;
    end else begin
      validQ <= 1'b1;
    end
  end

  always_comb begin
    strobe.captureEn = (winCnt < WIN_END);
    strobe.cfgValid  = validQ;
  end
endmodule

// File: rtl/strap_dp.sv
module strap_dp
  import strap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strapStrobe_t         strobe,
  input  logic                 modePinIn,
  input  logic                 hsSelPinIn,
  input  logic                 ssSelPinIn,
  input  logic                 vctl1PinIn,
  input  logic                 commReqPinIn,
  input  logic                 hostHsSel,
  input  logic                 hostSsSel,
  input  logic                 laneModeIn,
  output logic                 hsSelPinOut,
  output logic                 hsSelPinOe,
  output logic                 ssSelPinOut,
  output logic                 ssSelPinOe,
  output logic [NUM_RAILS-1:0] vctlPinOut,
  output logic [NUM_RAILS-1:0] vctlPinOe,
  output logic                 isHost,
  output logic                 isDongle,
  output logic                 fwUpdate,
  output logic [1:0]           voltCode,
  output logic [NUM_RAILS-1:0] railEn,
  output logic                 fourLane,
  output logic                 commReq
);
  logic       hostQ;
  logic       dongleQ;
  logic       fwQ;
  logic [1:0] codeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostQ   <= 1'b0;
      dongleQ <= 1'b0;
      fwQ     <= 1'b0;
      codeQ   <= 2'b00;
    end else if (strobe.captureEn) begin
      hostQ   <= modePinIn;
      dongleQ <= vctl1PinIn;
      fwQ     <= commReqPinIn;
      codeQ   <= {hsSelPinIn, ssSelPinIn};
    end
  end

  logic hostLive;
  logic dockLive;
  logic [NUM_RAILS-1:0] railDec;

  always_comb begin
    hostLive = strobe.cfgValid && hostQ;
    dockLive = strobe.cfgValid && !hostQ;
    railDec  = decodeRail(codeQ);
  end

  assign isHost   = hostQ;
  assign isDongle = dongleQ && !hostQ;
  assign fwUpdate = fwQ;
  assign voltCode = codeQ;

  assign railEn   = (dockLive && !fwQ) ? railDec : '0;
  assign fourLane = dockLive && laneModeIn;
  assign commReq  = strobe.cfgValid && commReqPinIn;

  assign hsSelPinOe  = hostLive;
  assign ssSelPinOe  = hostLive;
  assign hsSelPinOut = hostLive && hostHsSel;
  assign ssSelPinOut = hostLive && hostSsSel;

  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_vctl
    assign vctlPinOe[i]  = dockLive;
    assign vctlPinOut[i] = railEn[i];
  end
endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
  import strap_pkg::*;
#(
  parameter int CAPTURE_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modePinIn,
  input  logic                 hsSelPinIn,
  output logic                 hsSelPinOut,
  output logic                 hsSelPinOe,
  input  logic                 ssSelPinIn,
  output logic                 ssSelPinOut,
  output logic                 ssSelPinOe,
  input  logic                 vctl1PinIn,
  output logic [NUM_RAILS-1:0] vctlPinOut,
  output logic [NUM_RAILS-1:0] vctlPinOe,
  input  logic                 commReqPinIn,
  input  logic                 hostHsSel,
  input  logic                 hostSsSel,
  input  logic                 laneModeIn,
  output logic                 cfgValid,
  output logic                 isHost,
  output logic                 isDongle,
  output logic                 fwUpdate,
  output logic [1:0]           voltCode,
  output logic [NUM_RAILS-1:0] railEn,
  output logic                 fourLane,
  output logic                 commReq
);
  strapStrobe_t strobe;

  strap_ctrl #(.CAPTURE_CYCLES(CAPTURE_CYCLES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe)
  );

  strap_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .modePinIn    (modePinIn),
    .hsSelPinIn   (hsSelPinIn),
    .ssSelPinIn   (ssSelPinIn),
    .vctl1PinIn   (vctl1PinIn),
    .commReqPinIn (commReqPinIn),
    .hostHsSel    (hostHsSel),
    .hostSsSel    (hostSsSel),
    .laneModeIn   (laneModeIn),
    .hsSelPinOut  (hsSelPinOut),
    .hsSelPinOe   (hsSelPinOe),
    .ssSelPinOut  (ssSelPinOut),
    .ssSelPinOe   (ssSelPinOe),
    .vctlPinOut   (vctlPinOut),
    .vctlPinOe    (vctlPinOe),
    .isHost       (isHost),
    .isDongle     (isDongle),
    .fwUpdate     (fwUpdate),
    .voltCode     (voltCode),
    .railEn       (railEn),
    .fourLane     (fourLane),
    .commReq      (commReq)
  );

  assign cfgValid = strobe.cfgValid;
endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       cfgValid,
  input logic       isHost,
  input logic       isDongle,
  input logic       fwUpdate,
  input logic [1:0] voltCode,
  input logic [2:0] railEn,
  input logic       hsSelPinOe,
  input logic       ssSelPinOe,
  input logic       hsSelPinOut,
  input logic [2:0] vctlPinOe,
  input logic       hostHsSel,
  input logic       fourLane
);
  // R5
  oe_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgValid |-> (!hsSelPinOe && !ssSelPinOe && vctlPinOe == 3'b000));

  // R5
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |=> cfgValid);

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && $past(cfgValid)) |->
      ($stable(voltCode) && $stable(isHost) && $stable(fwUpdate) && $stable(isDongle)));

  // R8
  rail_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(railEn));

  // R8
  rail_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwUpdate || voltCode == 2'b00 || isHost) |-> railEn == 3'b000);

  // R7
  host_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && isHost) |-> (hsSelPinOe && ssSelPinOe && hsSelPinOut == hostHsSel));

  // R10
  lane_host_chk: assert property (@(posedge clk) disable iff (!rstN)
    isHost |-> !fourLane);
endmodule

bind strap_cfg_top strap_cfg_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cfgValid    (cfgValid),
  .isHost      (isHost),
  .isDongle    (isDongle),
  .fwUpdate    (fwUpdate),
  .voltCode    (voltCode),
  .railEn      (railEn),
  .hsSelPinOe  (hsSelPinOe),
  .ssSelPinOe  (ssSelPinOe),
  .hsSelPinOut (hsSelPinOut),
  .vctlPinOe   (vctlPinOe),
  .hostHsSel   (hostHsSel),
  .fourLane    (fourLane)
);

// File: tb/strap_cfg_top_tb.sv
module strap_cfg_top_tb;
  localparam int WIN = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic modeStrap = 0, hsStrap = 0, ssStrap = 0, v1Strap = 0, crPin = 0;
  logic hostHsSel = 0, hostSsSel = 0, laneModeIn = 0;

  logic hsSelPinIn, ssSelPinIn, vctl1PinIn;
  logic hsSelPinOut, hsSelPinOe, ssSelPinOut, ssSelPinOe;
  logic [2:0] vctlPinOut, vctlPinOe, railEn;
  logic cfgValid, isHost, isDongle, fwUpdate, fourLane, commReq;
  logic [1:0] voltCode;

  // board-level pin resolution: a driven pin shows its own drive
  assign hsSelPinIn = hsSelPinOe   ? hsSelPinOut   : hsStrap;
  assign ssSelPinIn = ssSelPinOe   ? ssSelPinOut   : ssStrap;
  assign vctl1PinIn = vctlPinOe[0] ? vctlPinOut[0] : v1Strap;

  strap_cfg_top #(.CAPTURE_CYCLES(WIN)) u_dut (
    .clk(clk), .rstN(rstN), .modePinIn(modeStrap),
    .hsSelPinIn(hsSelPinIn), .hsSelPinOut(hsSelPinOut), .hsSelPinOe(hsSelPinOe),
    .ssSelPinIn(ssSelPinIn), .ssSelPinOut(ssSelPinOut), .ssSelPinOe(ssSelPinOe),
    .vctl1PinIn(vctl1PinIn), .vctlPinOut(vctlPinOut), .vctlPinOe(vctlPinOe),
    .commReqPinIn(crPin), .hostHsSel(hostHsSel), .hostSsSel(hostSsSel),
    .laneModeIn(laneModeIn), .cfgValid(cfgValid), .isHost(isHost),
    .isDongle(isDongle), .fwUpdate(fwUpdate), .voltCode(voltCode),
    .railEn(railEn), .fourLane(fourLane), .commReq(commReq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] expRail(input logic [1:0] code);
    case (code)
      2'b01:   return 3'b010;
      2'b10:   return 3'b100;
      2'b11:   return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  task automatic runCase(input logic [4:0] s);
    logic m, h, ss, v, c;
    logic [2:0] rails;
    {m, h, ss, v, c} = s;
    @(negedge clk);
    rstN = 1'b0;
    modeStrap = m; hsStrap = h; ssStrap = ss; v1Strap = v; crPin = c;
    hostHsSel = 0; hostSsSel = 0; laneModeIn = 0;
    @(negedge clk);
    chk("R5 reset valid", {7'd0, cfgValid}, 8'd0);
    chk("R5 reset oe", {3'd0, hsSelPinOe, ssSelPinOe, vctlPinOe}, 8'd0);
    rstN = 1'b1;
    for (int k = 1; k <= WIN; k++) begin
      @(negedge clk);
      chk("R5 window quiet", {3'd0, cfgValid, hsSelPinOe, ssSelPinOe, vctlPinOe[1:0]} | {7'd0, vctlPinOe[2]}, 8'd0);
      chk("R3 commReq gated", {7'd0, commReq}, 8'd0);
    end
    @(negedge clk);
    chk("R5 valid edge", {7'd0, cfgValid}, 8'd1);
    chk("R1 role", {7'd0, isHost}, {7'd0, m});
    chk("R2 volt code", {6'd0, voltCode}, {6'd0, h, ss});
    chk("R3 fw flag", {7'd0, fwUpdate}, {7'd0, c});
    chk("R4 sub-role", {7'd0, isDongle}, {7'd0, !m && v});
    rails = (!m && !c) ? expRail({h, ss}) : 3'b000;
    chk("R8 rails", {5'd0, railEn}, {5'd0, rails});
    if (m) begin
      chk("R9 host vctl oe", {5'd0, vctlPinOe}, 8'd0);
      for (int p = 0; p < 4; p++) begin
        {hostHsSel, hostSsSel} = 2'(p);
        #1;
        chk("R7 host sel", {4'd0, hsSelPinOe, ssSelPinOe, hsSelPinOut, ssSelPinOut},
            {4'd0, 2'b11, 2'(p)});
      end
      laneModeIn = 1; #1;
      chk("R10 host lane", {7'd0, fourLane}, 8'd0);
    end else begin
      chk("R7 dock sel oe", {6'd0, hsSelPinOe, ssSelPinOe}, 8'd0);
      chk("R9 dock vctl", {2'd0, vctlPinOe, vctlPinOut}, {2'd0, 3'b111, rails});
      laneModeIn = 1; #1;
      chk("R10 four lane", {7'd0, fourLane}, 8'd1);
      laneModeIn = 0; #1;
      chk("R10 two lane", {7'd0, fourLane}, 8'd0);
    end
    crPin = !c; #1;
    chk("R3 commReq follows", {7'd0, commReq}, {7'd0, !c});
    modeStrap = !m; hsStrap = !h; ssStrap = !ss; v1Strap = !v;
    repeat (3) @(negedge clk);
    chk("R6 frozen", {2'd0, isHost, isDongle, fwUpdate, voltCode, cfgValid},
        {2'd0, m, !m && v, c, h, ss, 1'b1});
    chk("R8 rails frozen", {5'd0, railEn}, {5'd0, rails});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int s = 0; s < 32; s++) runCase(5'(s));
    // reassertion mid-run clears at once
    @(negedge clk);
    rstN = 1'b0; #1;
    chk("R5 async clear", {6'd0, cfgValid, |vctlPinOe | hsSelPinOe}, 8'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule